// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer. It runs on the output of an external dual-modulus prescaler. It holds a main count N and a swallow count A. Through a modulus-control output it tells the prescaler whether to divide the oscillator by M+1 or by M. Over one output period the prescaler spends A of its cycles at M+1 and N−A cycles at M. One output pulse therefore marks every M·N+A oscillator periods, so the locked oscillator runs at (M·N+A) times the comparison frequency.

A second output picks the prescaler pair: 64/65 or 128/129. Software writes N, A and the pair select with a one-cycle load strobe. The values are checked and held in a shadow store. The running counters take them only at the next period boundary, so no period ever mixes old and new settings. A load that breaks the rules is dropped, and an error flag reports it. For a wanted total ratio D, the settings are N = floor(D/M) and A = D − N·M. This split is usable whenever the resulting A is below N.

Top module: `psd_divider`

## Requirements
- R1: `div_pulse` is high for exactly one clock (prescaler-output) cycle per output period: the last of N cycles of the active setting.
- R2: `mod_high` (1 = prescaler divides by M+1, 0 = by M) is high for the first A cycles of each period and low for the remaining N−A. The period spans M·N+A oscillator cycles.
- R3: With A = 0, `mod_high` stays low for the whole period.
- R4: `psc_wide` = 0 selects M = 64 and 1 selects M = 128. It changes only at a period boundary, together with N and A.
- R5: A load is accepted when `cfg_valid` is high with 3 ≤ `cfg_n` ≤ 2047 and `cfg_a` < `cfg_n`. It takes effect at the first boundary after the edge that samples it, and the running period completes with the old values. A load sampled on the boundary edge itself applies one period later.
- R6: When several accepted loads arrive within one period, only the last one is used at the next boundary.
- R7: A rejected load (`cfg_n` < 3 or `cfg_a` ≥ `cfg_n`) leaves the stored setting unchanged. It sets `cfg_err` from the next cycle. `cfg_err` stays set until an accepted load clears it.
- R8: After synchronous active-low reset the setting is N = 64, A = 0, M = 64, with `cfg_err` = 0 and `div_pulse` = 0. The first period starts on the first cycle after reset.
- R9: For a total ratio D, loading N = floor(D/M) and A = D − N·M (with A < N) gives a period of exactly D oscillator cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Load strobe for a new setting |
| cfg_n | input | 11 | Main count N |
| cfg_a | input | 7 | Swallow count A |
| cfg_wide | input | 1 | Prescaler pair select to load (0: 64/65, 1: 128/129) |
| mod_high | output | 1 | Modulus control, 1 = divide by M+1 |
| psc_wide | output | 1 | Active prescaler pair select |
| div_pulse | output | 1 | One-cycle pulse at the end of each period |
| cfg_err | output | 1 | Last load was rejected |

## Verification
The bench models the prescaler as a behavioural divide-by-M-or-M+1 stage. It counts oscillator cycles per period against M·N+A.

The corner cases it targets are:
- A = 0 and the largest A allowed by N; a design that misses these would leave the prescaler at M+1 for a spurious cycle, or swallow too few pulses.
- The minimum N of 3.
- The wide prescaler pair.
- A load landing mid-period or exactly on the boundary edge; a design that applied it at once would produce one period of mixed length.
- Back-to-back loads.
- Rejected loads; a design that accepted them would change the period or leave the error flag stale.
- Split-derived ratios.

// File: rtl/psd_pkg.sv
// Package: shared defaults and the modulus-control encoding for the
// pulse-swallow divider. Assumes N is never narrower than A.
package psd_pkg;
    localparam int DEF_N_W   = 11;
    localparam int DEF_A_W   = 7;
    localparam int DEF_N_MIN = 3;
    localparam int DEF_RST_N = 64;
    localparam int DEF_RST_A = 0;

    typedef enum logic {
        MOD_LOW  = 1'b0,   // prescaler divides by M
        MOD_HIGH = 1'b1    // prescaler divides by M+1
    } psd_mod_e;
endpackage

// File: rtl/psd_cfg_shadow.sv
// Module: validates load requests and keeps the latest accepted setting.
// Assumes: load fields are stable on the sampling edge; rejected loads
// change nothing but the error flag.
module psd_cfg_shadow
    import psd_pkg::*;
#(
    parameter int N_W   = DEF_N_W,
    parameter int A_W   = DEF_A_W,
    parameter int N_MIN = DEF_N_MIN,
    parameter int RST_N = DEF_RST_N,
    parameter int RST_A = DEF_RST_A
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_valid,
    input  logic [N_W-1:0] ld_n,
    input  logic [A_W-1:0] ld_a,
    input  logic           ld_wide,
    output logic [N_W-1:0] sh_n,
    output logic [A_W-1:0] sh_a,
    output logic           sh_wide,
    output logic           err
);
    logic legal;

    // Legality: N at least the minimum and strictly above A.
    always_comb begin
        legal = (ld_n >= N_W'(N_MIN)) && (N_W'(ld_a) < ld_n);
    end

    // Shadow store and error flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_n    <= N_W'(RST_N);
            sh_a    <= A_W'(RST_A);
            sh_wide <= 1'b0;
            err     <= 1'b0;
        end else if (ld_valid) begin
            if (legal) begin
                sh_n    <= ld_n;
                sh_a    <= ld_a;
                sh_wide <= ld_wide;
                err     <= 1'b0;
            end else begin
                err     <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/psd_swallow_core.sv
// Module: main and swallow down-counters. Both reload from the shadow
// setting on the terminal cycle of the main counter.
// Assumes: shadow values satisfy N >= 3 and A < N.
module psd_swallow_core
    import psd_pkg::*;
#(
    parameter int N_W   = DEF_N_W,
    parameter int A_W   = DEF_A_W,
    parameter int RST_N = DEF_RST_N,
    parameter int RST_A = DEF_RST_A
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] sh_n,
    input  logic [A_W-1:0] sh_a,
    input  logic           sh_wide,
    output psd_mod_e       mod_sel,
    output logic           wide_q,
    output logic           term
);
    logic [N_W-1:0] n_cnt;
    logic [A_W-1:0] a_cnt;

    // Terminal cycle and modulus request derived from counter state.
    always_comb begin
        term    = (n_cnt == '0);
        mod_sel = (a_cnt != '0) ? MOD_HIGH : MOD_LOW;
    end

    // Count down; reload everything at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_cnt  <= N_W'(RST_N - 1);
            a_cnt  <= A_W'(RST_A);
            wide_q <= 1'b0;
        end else if (term) begin
            n_cnt  <= sh_n - N_W'(1);
            a_cnt  <= sh_a;
            wide_q <= sh_wide;
        end else begin
            n_cnt  <= n_cnt - N_W'(1);
            if (a_cnt != '0) begin
                a_cnt <= a_cnt - A_W'(1);
            end
        end
    end
endmodule

// File: rtl/psd_divider.sv
// Module: top of the pulse-swallow feedback divider. Clocked by the
// prescaler output; drives modulus control and pair select back to it.
// Assumes: the prescaler samples mod_high once per its own cycle.
module psd_divider
    import psd_pkg::*;
#(
    parameter int N_W   = DEF_N_W,
    parameter int A_W   = DEF_A_W,
    parameter int N_MIN = DEF_N_MIN,
    parameter int RST_N = DEF_RST_N,
    parameter int RST_A = DEF_RST_A
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_valid,
    input  logic [N_W-1:0] cfg_n,
    input  logic [A_W-1:0] cfg_a,
    input  logic           cfg_wide,
    output logic           mod_high,
    output logic           psc_wide,
    output logic           div_pulse,
    output logic           cfg_err
);
    logic [N_W-1:0] sh_n;
    logic [A_W-1:0] sh_a;
    logic           sh_wide;
    psd_mod_e       mod_sel;
    logic           term;

    psd_cfg_shadow #(
        .N_W(N_W), .A_W(A_W), .N_MIN(N_MIN), .RST_N(RST_N), .RST_A(RST_A)
    ) shadow_i (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(cfg_valid), .ld_n(cfg_n), .ld_a(cfg_a), .ld_wide(cfg_wide),
        .sh_n(sh_n), .sh_a(sh_a), .sh_wide(sh_wide), .err(cfg_err)
    );

    psd_swallow_core #(
        .N_W(N_W), .A_W(A_W), .RST_N(RST_N), .RST_A(RST_A)
    ) core_i (
        .clk(clk), .rst_n(rst_n),
        .sh_n(sh_n), .sh_a(sh_a), .sh_wide(sh_wide),
        .mod_sel(mod_sel), .wide_q(psc_wide), .term(term)
    );

    // Output mapping.
    always_comb begin
        mod_high  = (mod_sel == MOD_HIGH);
        div_pulse = term;
    end
endmodule

// File: rtl/psd_divider_chk.sv
// Module: assertion checker for psd_divider, attached through bind.
// Assumes: synchronous active-low reset; all ports observed at clk.
module psd_divider_chk #(
    parameter int N_W   = 11,
    parameter int A_W   = 7,
    parameter int N_MIN = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_valid,
    input logic [N_W-1:0] cfg_n,
    input logic [A_W-1:0] cfg_a,
    input logic           cfg_wide,
    input logic           mod_high,
    input logic           psc_wide,
    input logic           div_pulse,
    input logic           cfg_err
);
    // R1
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R2
    mod_low_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> !mod_high);

    // R2
    mod_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_high && !div_pulse) |=> !mod_high);

    // R4
    wide_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !div_pulse |=> $stable(psc_wide));

    // R7
    reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && ((cfg_n < N_W'(N_MIN)) || (N_W'(cfg_a) >= cfg_n))) |=> cfg_err);

    // R7
    accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && (cfg_n >= N_W'(N_MIN)) && (N_W'(cfg_a) < cfg_n)) |=> !cfg_err);

    // R4
    wide_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({psc_wide, cfg_wide}) || !cfg_valid);
endmodule

bind psd_divider psd_divider_chk #(.N_W(N_W), .A_W(A_W), .N_MIN(N_MIN)) chk_i (.*);

// File: tb/psd_divider_tb.sv
`timescale 1ns/1ps
module psd_divider_tb_top;
    logic        vco_clk = 1'b0;
    logic        psc_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [10:0] cfg_n = '0;
    logic [6:0]  cfg_a = '0;
    logic        cfg_wide = 1'b0;
    logic        mod_high, psc_wide, div_pulse, cfg_err;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // prescaler and reference model state
    int pc = 0;
    int per_acc = 0;
    int last_per = 0;
    int vco_total = 0;
    bit armed = 1'b0;
    int m_idx, m_act_n, m_act_a, m_sh_n, m_sh_a;
    bit m_act_w, m_sh_w, m_err;
    int cur_n, cur_a;
    bit cur_w;

    psd_divider dut_i (
        .clk(psc_clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_n(cfg_n),
        .cfg_a(cfg_a), .cfg_wide(cfg_wide), .mod_high(mod_high),
        .psc_wide(psc_wide), .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    always #5 vco_clk = ~vco_clk;

    function automatic int exp_ratio(input int n, input int a, input bit w);
        return (w ? 128 : 64) * n + a;
    endfunction

    function automatic bit is_legal(input int n, input int a);
        return (n >= 3) && (n <= 2047) && (a < n);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // behavioural prescaler (divide by M or M+1) plus per-cycle reference model
    always @(posedge vco_clk) begin
        int term;
        vco_total++;
        term = 63 + ((psc_wide === 1'b1) ? 64 : 0) + ((mod_high === 1'b1) ? 1 : 0);
        if (pc >= term) begin
            per_acc += term + 1;
            if (!rst_n) begin
                armed = 1'b1; m_idx = 0; per_acc = 0;
                m_act_n = 64; m_act_a = 0; m_act_w = 1'b0;
                m_sh_n = 64; m_sh_a = 0; m_sh_w = 1'b0; m_err = 1'b0;
            end else if (armed) begin
                chk(mod_high === (m_idx < m_act_a), (m_act_a == 0) ? "R3 mod" : "R2 mod",
                    int'(mod_high), int'(m_idx < m_act_a));
                chk(div_pulse === (m_idx == m_act_n - 1), "R1 pulse",
                    int'(div_pulse), int'(m_idx == m_act_n - 1));
                chk(psc_wide === m_act_w, "R4 pair", int'(psc_wide), int'(m_act_w));
                chk(cfg_err === m_err, "R7 flag", int'(cfg_err), int'(m_err));
                if (m_idx == m_act_n - 1) begin
                    chk(per_acc == exp_ratio(m_act_n, m_act_a, m_act_w), "R2 ratio",
                        per_acc, exp_ratio(m_act_n, m_act_a, m_act_w));
                    last_per = per_acc;
                    per_acc = 0;
                    m_idx = 0;
                    m_act_n = m_sh_n; m_act_a = m_sh_a; m_act_w = m_sh_w;
                end else begin
                    m_idx++;
                end
                if (cfg_valid) begin
                    if (is_legal(int'(cfg_n), int'(cfg_a))) begin
                        m_sh_n = int'(cfg_n); m_sh_a = int'(cfg_a); m_sh_w = cfg_wide;
                        m_err = 1'b0;
                    end else begin
                        m_err = 1'b1;
                    end
                end
            end
            pc = 0;
        end else begin
            pc++;
        end
        psc_clk <= (pc < 16);
    end

    // watchdog
    always @(posedge vco_clk) begin
        if (vco_total > 190000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", vco_total, 190000);
            finish_run();
        end
    end

    task automatic load(input int n, input int a, input bit w);
        @(negedge psc_clk);
        cfg_n = 11'(n); cfg_a = 7'(a); cfg_wide = w; cfg_valid = 1'b1;
        @(negedge psc_clk);
        cfg_valid = 1'b0;
    endtask

    task automatic load_at_boundary(input int n, input int a, input bit w);
        do @(negedge psc_clk); while (div_pulse !== 1'b1);
        cfg_n = 11'(n); cfg_a = 7'(a); cfg_wide = w; cfg_valid = 1'b1;
        @(negedge psc_clk);
        cfg_valid = 1'b0;
    endtask

    task automatic wait_periods(input int k);
        repeat (k) begin
            do @(negedge psc_clk); while (div_pulse !== 1'b1);
            @(posedge psc_clk);
        end
        @(negedge psc_clk);
    endtask

    initial begin
        int n, a, d;
        bit w;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge psc_clk);
        rst_n = 1'b1;
        @(negedge psc_clk);
        // R8 reset state
        chk(div_pulse === 1'b0, "R8 pulse", int'(div_pulse), 0);
        chk(mod_high === 1'b0, "R8 mod", int'(mod_high), 0);
        chk(psc_wide === 1'b0, "R8 pair", int'(psc_wide), 0);
        chk(cfg_err === 1'b0, "R8 err", int'(cfg_err), 0);
        wait_periods(1);
        chk(last_per == 4096, "R8 period", last_per, 4096);

        // R5 mid-period load: old period completes first
        load(6, 2, 1'b0);
        wait_periods(1);
        chk(last_per == 4096, "R5 old", last_per, 4096);
        wait_periods(1);
        chk(last_per == 386, "R5 new", last_per, 386);

        // R5 load sampled on the boundary edge applies one period later
        load_at_boundary(8, 3, 1'b0);
        wait_periods(1);
        chk(last_per == 386, "R5 boundary old", last_per, 386);
        wait_periods(1);
        chk(last_per == 515, "R5 boundary new", last_per, 515);

        // R6 back-to-back loads: last one wins
        load(5, 1, 1'b0);
        load(7, 6, 1'b0);
        wait_periods(1);
        chk(last_per == 515, "R6 old", last_per, 515);
        wait_periods(1);
        chk(last_per == 454, "R6 last", last_per, 454);

        // R3 A=0 with minimum N
        load(3, 0, 1'b0);
        wait_periods(2);
        chk(last_per == 192, "R3 ratio", last_per, 192);

        // R7 rejected loads
        load(5, 5, 1'b1);
        chk(cfg_err === 1'b1, "R7 a>=n err", int'(cfg_err), 1);
        wait_periods(2);
        chk(last_per == 192, "R7 kept", last_per, 192);
        load(2, 0, 1'b0);
        chk(cfg_err === 1'b1, "R7 n<3 err", int'(cfg_err), 1);
        wait_periods(2);
        chk(last_per == 192, "R7 kept2", last_per, 192);
        load(4, 3, 1'b0);
        chk(cfg_err === 1'b0, "R7 clear", int'(cfg_err), 0);
        wait_periods(2);
        chk(last_per == 259, "R7 accepted", last_per, 259);

        // R4 wide pair, then largest A
        load(10, 7, 1'b1);
        wait_periods(2);
        chk(last_per == 1287, "R4 wide", last_per, 1287);
        load(128, 127, 1'b0);
        wait_periods(2);
        chk(last_per == 8319, "R2 max A", last_per, 8319);

        // R9 split of a total ratio
        d = 1290;
        n = d / 64; a = d - n * 64;
        load(n, a, 1'b0);
        wait_periods(2);
        chk(last_per == d, "R9 narrow", last_per, d);
        d = 2570;
        n = d / 128; a = d - n * 128;
        load(n, a, 1'b1);
        wait_periods(2);
        chk(last_per == d, "R9 wide", last_per, d);
        cur_n = n; cur_a = a; cur_w = 1'b1;

        // random mix of legal and illegal loads
        for (int i = 0; i < 10; i++) begin
            n = 3 + int'($urandom % 14);
            if ($urandom % 4 == 0) a = n + int'($urandom % 3);
            else a = int'($urandom % n);
            w = 1'($urandom % 2);
            load(n, a, w);
            if (is_legal(n, a)) begin
                cur_n = n; cur_a = a; cur_w = w;
            end
            chk(cfg_err === !is_legal(n, a), "R7 random err", int'(cfg_err), int'(!is_legal(n, a)));
            wait_periods(2);
            chk(last_per == exp_ratio(cur_n, cur_a, cur_w), "R2 random",
                last_per, exp_ratio(cur_n, cur_a, cur_w));
        end
        finish_run();
    end
endmodule